// File: doc/BRIEF.md
# I2C Bus Start and Stop Condition Detector

This block watches the clock and data wires of an I2C bus from inside a slave and recognises the two framing conditions in hardware. A slave has no time to do this in software. The data wire may not fall while the clock wire is high, except to mark the opening of a transfer. It may not rise while the clock wire is high, except to mark its end. Both wires are oversampled on the system clock. Each wire passes through a two-flop synchronizer and a three-sample majority filter, so single-cycle spikes never reach the edge logic.

A detected opening condition produces a one-cycle strobe. That strobe tells the downstream address-compare stage that the next byte on the wire (or the next two, for 10-bit addressing) carries the slave address. A repeated opening condition, seen while the bus is already busy, uses the same strobe. A detected closing condition sets a sticky status bit and, when its enable is set, a sticky interrupt line. A read strobe from the status register clears both. The block also tracks whether the bus is busy. Detection is active only while the I2C-mode enable input is high.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset, startPulse, stopStatus, stopIrq and busBusy are all 0, and both filtered lines are taken as high.
- R2: With modeEn high, a falling edge of SDA while SCL stays high produces exactly one startPulse, lasting one cycle, and sets busBusy.
- R3: With modeEn high, a rising edge of SDA while SCL stays high sets stopStatus, which stays 1 until it is cleared, and clears busBusy.
- R4: Changes of SDA while SCL is low produce no startPulse and leave stopStatus and busBusy unchanged.
- R5: A detected STOP sets stopIrq only if stopIrqEn is 1 at that time. Otherwise stopIrq is unchanged.
- R6: A statusRd pulse with no coinciding STOP clears both stopStatus and stopIrq to 0.
- R7: A STOP whose detection strobe coincides with statusRd wins: stopStatus (and stopIrq, if enabled) is 1 after that edge. With default parameters, that strobe falls on the fourth rising edge after the edge that first samples the SDA change.
- R8: While modeEn is 0, SDA edges with SCL high produce no startPulse and leave stopStatus, stopIrq and busBusy unchanged.
- R9: An SDA pulse lasting one system clock while SCL is high is rejected: it produces no startPulse and no stopStatus.
- R10: A START detected while busBusy is 1 (a repeated START) produces one startPulse, and busBusy stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw I2C clock wire |
| sdaIn | input | 1 | Raw I2C data wire |
| modeEn | input | 1 | I2C-mode enable; gates all detection |
| stopIrqEn | input | 1 | Enables stopIrq on a detected STOP |
| statusRd | input | 1 | Status-register read strobe; clears stopStatus and stopIrq |
| startPulse | output | 1 | One-cycle strobe on START or repeated START |
| stopStatus | output | 1 | Sticky STOP-seen status bit |
| stopIrq | output | 1 | Sticky STOP interrupt |
| busBusy | output | 1 | High from START until STOP |

## Verification
The sharpest corner is a STOP that lands in the same cycle as a status read. A design that let the read win would lose the event, and stopStatus would read 0 afterwards. The bench also drives a one-clock SDA spike with SCL high and SDA edges with SCL low. A filter that was too short, or an edge test that ignored SCL, would raise a false START or STOP there. Repeated START, the mode gate and the interrupt mask are each exercised. A design that dropped the repeated-START strobe, leaked events while disabled, or raised the interrupt while masked would show a wrong pulse count or a wrong sticky bit.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  parameter int SYNC_STAGES = 2;
  parameter int FILT_WIN = 3;

  typedef struct packed {
    logic start;
    logic stop;
  } condEv_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_WIN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic filtQ,
  output logic filtD
);
  localparam int HALF = FILT_WIN / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_WIN-1:0] winQ;

  // majority vote over the sample window
  always_comb filtD = ($countones(winQ) > HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      winQ  <= '1;
      filtQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      winQ  <= {winQ[FILT_WIN-2:0], syncQ[SYNC_STAGES-1]};
      filtQ <= filtD;
    end
  end
endmodule

// File: rtl/i2c_cond_datapath.sv
module i2c_cond_datapath
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = i2c_cond_pkg::SYNC_STAGES,
  parameter int FILT_WIN = i2c_cond_pkg::FILT_WIN
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output condEv_t ev
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLine;
  logic [NUM_LINES-1:0] lineQ;
  logic [NUM_LINES-1:0] lineD;

  assign rawLine = {sdaIn, sclIn};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    i2c_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_WIN(FILT_WIN)
    ) u_filt (
      .clk(clk),
      .rstN(rstN),
      .lineIn(rawLine[i]),
      .filtQ(lineQ[i]),
      .filtD(lineD[i])
    );
  end

  logic sclSteadyHigh;
  always_comb begin
    sclSteadyHigh = lineQ[0] & lineD[0];
    ev.start = sclSteadyHigh & lineQ[1] & ~lineD[1];
    ev.stop  = sclSteadyHigh & ~lineQ[1] & lineD[1];
  end
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  condEv_t ev,
  input  logic    modeEn,
  input  logic    stopIrqEn,
  input  logic    statusRd,
  output logic    startPulse,
  output logic    stopStatus,
  output logic    stopIrq,
  output logic    busBusy
);
  logic startHit;
  logic stopHit;

  always_comb begin
    startHit = modeEn & ev.start;
    stopHit  = modeEn & ev.stop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse <= 1'b0;
      stopStatus <= 1'b0;
      stopIrq    <= 1'b0;
      busBusy    <= 1'b0;
    end else begin
      startPulse <= startHit;
      if (stopHit) stopStatus <= 1'b1;
      else if (statusRd) stopStatus <= 1'b0;
      if (stopHit && stopIrqEn) stopIrq <= 1'b1;
      else if (statusRd) stopIrq <= 1'b0;
      if (startHit) busBusy <= 1'b1;
      else if (stopHit) busBusy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic modeEn,
  input  logic stopIrqEn,
  input  logic statusRd,
  output logic startPulse,
  output logic stopStatus,
  output logic stopIrq,
  output logic busBusy
);
  condEv_t ev;

  i2c_cond_datapath u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ev(ev)
  );

  i2c_cond_ctrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .ev(ev),
    .modeEn(modeEn),
    .stopIrqEn(stopIrqEn),
    .statusRd(statusRd),
    .startPulse(startPulse),
    .stopStatus(stopStatus),
    .stopIrq(stopIrq),
    .busBusy(busBusy)
  );
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
  input logic clk,
  input logic rstN,
  input logic modeEn,
  input logic stopIrqEn,
  input logic statusRd,
  input logic startPulse,
  input logic stopStatus,
  input logic stopIrq,
  input logic busBusy
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> busBusy);

  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopIrq) |-> $past(stopIrqEn));

  p_irq_implies_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |-> stopStatus);

  p_clear_by_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stopStatus) || $fell(stopIrq)) |-> $past(statusRd));

  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && !statusRd) |=> (!startPulse && $stable(stopStatus)
                                && $stable(stopIrq) && $stable(busBusy)));
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .modeEn(modeEn),
  .stopIrqEn(stopIrqEn),
  .statusRd(statusRd),
  .startPulse(startPulse),
  .stopStatus(stopStatus),
  .stopIrq(stopIrq),
  .busBusy(busBusy)
);

// File: tb/i2c_cond_detect_tb.sv
module i2c_cond_detect_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic modeEn = 1'b0;
  logic stopIrqEn = 1'b0;
  logic statusRd = 1'b0;
  logic startPulse, stopStatus, stopIrq, busBusy;

  int checks = 0;
  int fails = 0;
  int startCount = 0;
  int maxPulseLen = 0;
  int curPulseLen = 0;

  always #2 clk = ~clk;

  i2c_cond_detect u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .modeEn(modeEn), .stopIrqEn(stopIrqEn), .statusRd(statusRd),
    .startPulse(startPulse), .stopStatus(stopStatus),
    .stopIrq(stopIrq), .busBusy(busBusy)
  );

  always @(negedge clk) begin
    if (startPulse) begin
      startCount++;
      curPulseLen++;
      if (curPulseLen > maxPulseLen) maxPulseLen = curPulseLen;
    end else begin
      curPulseLen = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearCounts();
    startCount = 0;
    maxPulseLen = 0;
  endtask

  task automatic drive(input bit scl, input bit sda);
    @(negedge clk);
    sclIn = scl;
    sdaIn = sda;
    step(10);
  endtask

  task automatic doRead();
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    step(1);
  endtask

  task automatic busIdle();
    drive(1'b1, 1'b1);
  endtask

  task automatic genStart();
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic genStop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
  endtask

  task automatic testReset();
    check(startPulse == 0, "R1 startPulse", startPulse, 0);
    check(stopStatus == 0, "R1 stopStatus", stopStatus, 0);
    check(stopIrq == 0, "R1 stopIrq", stopIrq, 0);
    check(busBusy == 0, "R1 busBusy", busBusy, 0);
  endtask

  task automatic testStart();
    clearCounts();
    genStart();
    check(startCount == 1, "R2 start count", startCount, 1);
    check(maxPulseLen == 1, "R2 pulse width", maxPulseLen, 1);
    check(busBusy == 1, "R2 busy set", busBusy, 1);
  endtask

  task automatic testSclLow();
    clearCounts();
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    check(startCount == 0, "R4 no start", startCount, 0);
    check(stopStatus == 0, "R4 no stop", stopStatus, 0);
    check(busBusy == 1, "R4 busy held", busBusy, 1);
  endtask

  task automatic testRepeated();
    clearCounts();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    check(startCount == 1, "R10 repeated start", startCount, 1);
    check(busBusy == 1, "R10 busy stays", busBusy, 1);
  endtask

  task automatic testStopMasked();
    stopIrqEn = 1'b0;
    genStop();
    check(stopStatus == 1, "R3 status set", stopStatus, 1);
    check(busBusy == 0, "R3 busy cleared", busBusy, 0);
    check(stopIrq == 0, "R5 irq masked", stopIrq, 0);
    step(20);
    check(stopStatus == 1, "R3 status sticky", stopStatus, 1);
    doRead();
    check(stopStatus == 0, "R6 status cleared", stopStatus, 0);
  endtask

  task automatic testStopIrq();
    stopIrqEn = 1'b1;
    genStart();
    genStop();
    check(stopIrq == 1, "R5 irq set", stopIrq, 1);
    check(stopStatus == 1, "R3 status set irq", stopStatus, 1);
    doRead();
    check(stopIrq == 0, "R6 irq cleared", stopIrq, 0);
    check(stopStatus == 0, "R6 status cleared irq", stopStatus, 0);
  endtask

  task automatic testCollision();
    stopIrqEn = 1'b1;
    genStart();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    @(negedge clk);
    sdaIn = 1'b1;
    step(4);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    check(stopStatus == 1, "R7 stop beats read", stopStatus, 1);
    check(stopIrq == 1, "R7 irq beats read", stopIrq, 1);
    step(5);
    doRead();
  endtask

  task automatic testGated();
    modeEn = 1'b0;
    clearCounts();
    genStart();
    check(startCount == 0, "R8 no start when off", startCount, 0);
    check(busBusy == 0, "R8 busy unchanged", busBusy, 0);
    genStop();
    check(stopStatus == 0, "R8 no stop when off", stopStatus, 0);
    check(stopIrq == 0, "R8 no irq when off", stopIrq, 0);
    modeEn = 1'b1;
  endtask

  task automatic testGlitch();
    clearCounts();
    busIdle();
    @(negedge clk);
    sdaIn = 1'b0;
    @(negedge clk);
    sdaIn = 1'b1;
    step(12);
    check(startCount == 0, "R9 spike no start", startCount, 0);
    check(busBusy == 0, "R9 spike busy", busBusy, 0);
    check(stopStatus == 0, "R9 spike no stop", stopStatus, 0);
  endtask

  bit done = 0;

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);
    testReset();
    modeEn = 1'b1;
    busIdle();
    testStart();
    testSclLow();
    testRepeated();
    testStopMasked();
    testStopIrq();
    testCollision();
    testGated();
    testGlitch();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule